// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Interlock Controller

This block sits between the command logic of a motor or valve controller and the gate drivers of one half bridge. It takes a high-side command (active low) and a low-side command (active high) and produces registered enables for the two gates. In the normal interlock mode it never turns both gates on together. When one gate turns off, it keeps both gates off for a programmable number of clock cycles before the opposite gate may turn on.

A bypass mode removes both the interlock and the dead time. Each gate then follows its own command, so both may be on at once, as injector or solenoid loads need. A disabled mode and a separate global shutdown input force both gates off. With a 50 MHz clock, the default 8-bit dead-time value spans 20 ns to 5.1 µs in steps of 20 ns. This covers a window of 100 ns to 3.1 µs, and command rates of 50 kHz are far below the clock rate.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both `gate_hi` and `gate_lo` are 0.
- R2: `hi_cmd_n` is active low and `lo_cmd` is active high. The idle levels (`hi_cmd_n`=1, `lo_cmd`=0) keep both gates off. From the idle state in interlock mode, a single request reaches its gate one clock edge after it is sampled.
- R3: In interlock mode (`mode`=2'b00), when a gate turns off for a steady opposite request, both gates stay off for exactly `dt_cycles`+1 cycles, and then the opposite gate turns on.
- R4: The dead-time value is captured at the edge where a gate turns off. Later changes of `dt_cycles` do not lengthen or shorten the interval already running.
- R5: If the request changes during a dead interval, the interval restarts from the captured value and both gates remain off until it ends.
- R6: In interlock mode, a request for both switches (`hi_cmd_n`=0 and `lo_cmd`=1) leaves both gates as they were in the previous cycle, including during a dead interval.
- R7: After any cycle sampled in interlock mode, `gate_hi` and `gate_lo` are never both 1.
- R8: In bypass mode (`mode`=2'b01), one edge after sampling, `gate_hi` equals the inverse of `hi_cmd_n` and `gate_lo` equals `lo_cmd`. Both may be 1.
- R9: In disabled mode (`mode`=2'b10 or 2'b11), both gates go to 0 one edge after sampling, whatever the commands are.
- R10: While `shutdown` is 1, both gates go to 0 one edge after sampling, in every mode.
- R11: When interlock mode resumes after bypass, disabled or shutdown, both gates stay off for `dt_cycles`+1 cycles before any gate turns on. The value used is the one present in the last cycle before interlock resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd_n | input | 1 | High-side switch request, active low |
| lo_cmd | input | 1 | Low-side switch request, active high |
| mode | input | 2 | 00 interlock, 01 bypass, 1x disabled |
| dt_cycles | input | DT_W | Dead time in clock cycles (interval is this value + 1) |
| shutdown | input | 1 | Global force-off, active high |
| gate_hi | output | 1 | Registered high-side gate enable |
| gate_lo | output | 1 | Registered low-side gate enable |

## Verification
The assertions take for granted that every input is a clean synchronous level that is stable around the sampling edge. They also assume that `mode` and `shutdown` may change on any cycle, and that command glitches of one cycle are legal. The stimulus holds commands for random run lengths, so that dead intervals both complete and get cut short. It mixes all four mode codes and occasional shutdown pulses, and it changes `dt_cycles` at random, including during running intervals. All inputs are driven on the falling clock edge, so no sampled value is ever ambiguous.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  localparam logic [1:0] MODE_INTERLOCK = 2'b00;
  localparam logic [1:0] MODE_BYPASS    = 2'b01;

  // Encoding is {low request, high request}
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_HI   = 2'b01,
    REQ_LO   = 2'b10,
    REQ_BOTH = 2'b11
  } hb_req_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_HI   = 2'b01,
    PH_LO   = 2'b10,
    PH_DEAD = 2'b11
  } hb_phase_e;

  function automatic hb_phase_e phase_for(input hb_req_e r);
    case (r)
      REQ_HI:  return PH_HI;
      REQ_LO:  return PH_LO;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_dt_pkg::*;
(
  input  logic    hi_cmd_n,
  input  logic    lo_cmd,
  output hb_req_e req,
  output logic    conflict
);

  always_comb begin
    req      = hb_req_e'({lo_cmd, ~hi_cmd_n});
    conflict = (req == REQ_BOTH);
  end

endmodule

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            reload,
  input  logic            step,
  input  logic [DT_W-1:0] dt_in,
  output logic            expired
);

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else if (load) begin
      lat_q <= dt_in;
      cnt_q <= dt_in;
    end else if (reload) begin
      cnt_q <= lat_q;
    end else if (step && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R4: the running count never exceeds the captured dead-time value
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lat_q);

  // R5: a restart request brings the count back to the captured value
  assert_restart_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (reload && !load) |=> (cnt_q == $past(lat_q)));

endmodule

// File: rtl/hb_interlock_fsm.sv
module hb_interlock_fsm
  import hb_dt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      force_safe,
  input  hb_req_e   req,
  input  logic      expired,
  output hb_phase_e phase_n,
  output logic      load,
  output logic      reload,
  output logic      step
);

  hb_phase_e phase_q;
  hb_req_e   pend_q;
  hb_req_e   pend_n;

  always_comb begin
    phase_n = phase_q;
    pend_n  = pend_q;
    load    = 1'b0;
    reload  = 1'b0;
    step    = 1'b0;
    if (force_safe) begin
      phase_n = PH_DEAD;
      pend_n  = REQ_NONE;
      load    = 1'b1;
    end else if (req != REQ_BOTH) begin
      unique case (phase_q)
        PH_IDLE: phase_n = phase_for(req);
        PH_HI: if (req != REQ_HI) begin
          phase_n = PH_DEAD;
          pend_n  = req;
          load    = 1'b1;
        end
        PH_LO: if (req != REQ_LO) begin
          phase_n = PH_DEAD;
          pend_n  = req;
          load    = 1'b1;
        end
        PH_DEAD: begin
          if (req != pend_q) begin
            pend_n = req;
            reload = 1'b1;
          end else if (expired) begin
            phase_n = phase_for(pend_q);
          end else begin
            step = 1'b1;
          end
        end
        default: phase_n = PH_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pend_q  <= REQ_NONE;
    end else begin
      phase_q <= phase_n;
      pend_q  <= pend_n;
    end
  end

  // R3: conduction never passes straight from one side to the other
  assert_no_direct_swap_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HI) |=> (phase_q != PH_LO));
  assert_no_direct_swap_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LO) |=> (phase_q != PH_HI));

endmodule

// File: rtl/hb_gate_out.sv
module hb_gate_out
  import hb_dt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       shutdown,
  input  logic       hi_cmd_n,
  input  logic       lo_cmd,
  input  logic       conflict,
  input  hb_phase_e  phase_n,
  output logic       gate_hi,
  output logic       gate_lo
);

  logic off_now, byp_now, il_go, byp_go;
  logic hi_d, lo_d;

  always_comb begin
    off_now = shutdown || mode[1];
    byp_now = (mode == MODE_BYPASS);
    il_go   = !rst && !off_now && (mode == MODE_INTERLOCK);
    byp_go  = !rst && !off_now && byp_now;
    if (off_now) begin
      hi_d = 1'b0;
      lo_d = 1'b0;
    end else if (byp_now) begin
      hi_d = ~hi_cmd_n;
      lo_d = lo_cmd;
    end else begin
      hi_d = (phase_n == PH_HI);
      lo_d = (phase_n == PH_LO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= hi_d;
      gate_lo <= lo_d;
    end
  end

  assert_never_both_R7: assert property (@(posedge clk) disable iff (rst)
    $past(il_go) |-> !(gate_hi && gate_lo));

  assert_forced_off_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode[1]) |-> (!gate_hi && !gate_lo));

  assert_shutdown_off_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && shutdown) |-> (!gate_hi && !gate_lo));

  assert_bypass_follow_R8: assert property (@(posedge clk) disable iff (rst)
    $past(byp_go) |-> (gate_hi == !$past(hi_cmd_n)) && (gate_lo == $past(lo_cmd)));

  assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(il_go) && $past(il_go, 2) && $past(conflict)) |-> ($stable(gate_hi) && $stable(gate_lo)));

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_dt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hi_cmd_n,
  input  logic            lo_cmd,
  input  logic [1:0]      mode,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            shutdown,
  output logic            gate_hi,
  output logic            gate_lo
);

  hb_req_e   req;
  logic      conflict;
  logic      force_safe;
  logic      expired, load, reload, step;
  hb_phase_e phase_n;

  assign force_safe = shutdown || (mode != MODE_INTERLOCK);

  hb_cmd_decode u_decode (
    .hi_cmd_n (hi_cmd_n),
    .lo_cmd   (lo_cmd),
    .req      (req),
    .conflict (conflict)
  );

  hb_dt_timer #(.DT_W(DT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .reload  (reload),
    .step    (step),
    .dt_in   (dt_cycles),
    .expired (expired)
  );

  hb_interlock_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .force_safe (force_safe),
    .req        (req),
    .expired    (expired),
    .phase_n    (phase_n),
    .load       (load),
    .reload     (reload),
    .step       (step)
  );

  hb_gate_out u_out (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .shutdown (shutdown),
    .hi_cmd_n (hi_cmd_n),
    .lo_cmd   (lo_cmd),
    .conflict (conflict),
    .phase_n  (phase_n),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
  );

  // R1: the cycle right after reset shows both gates off
  assert_reset_off_R1: assert property (@(posedge clk)
    $past(rst) |-> (!gate_hi && !gate_lo));

endmodule

// File: tb/test_hb_deadtime_ctrl.sv
module test_hb_deadtime_ctrl;

  localparam int DT_W = 8;
  localparam logic [1:0] IL  = 2'b00;
  localparam logic [1:0] BYP = 2'b01;

  logic            clk = 1'b0;
  logic            rst;
  logic            hi_cmd_n, lo_cmd, shutdown;
  logic [1:0]      mode;
  logic [DT_W-1:0] dt_cycles;
  logic            gate_hi, gate_lo;

  int checks = 0;
  int errors = 0;

  // reference model state: st 0 idle,1 hi,2 lo,3 dead; pend 0 none,1 hi,2 lo
  int m_st, m_pend, m_cnt, m_dtl;
  logic m_gh, m_gl;

  always #10 clk = ~clk;

  hb_deadtime_ctrl #(.DT_W(DT_W)) i_hb_deadtime_ctrl (
    .clk(clk), .rst(rst), .hi_cmd_n(hi_cmd_n), .lo_cmd(lo_cmd), .mode(mode),
    .dt_cycles(dt_cycles), .shutdown(shutdown), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  function automatic int st_of(input int r);
    return (r == 1) ? 1 : (r == 2) ? 2 : 0;
  endfunction

  task automatic model_edge();
    int r;
    if (rst) begin
      m_st = 0; m_pend = 0; m_cnt = 0; m_dtl = 0; m_gh = 0; m_gl = 0;
    end else if (shutdown || mode != IL) begin
      m_st = 3; m_pend = 0; m_cnt = int'(dt_cycles); m_dtl = int'(dt_cycles);
      m_gh = (mode == BYP && !shutdown) ? !hi_cmd_n : 1'b0;
      m_gl = (mode == BYP && !shutdown) ? lo_cmd : 1'b0;
    end else begin
      r = (lo_cmd ? 2 : 0) + (hi_cmd_n ? 0 : 1);
      if (r != 3) begin
        case (m_st)
          0: m_st = st_of(r);
          1, 2: if (r != m_st) begin
            m_st = 3; m_pend = r; m_cnt = int'(dt_cycles); m_dtl = int'(dt_cycles);
          end
          default: begin
            if (r != m_pend) begin m_pend = r; m_cnt = m_dtl; end
            else if (m_cnt == 0) m_st = st_of(m_pend);
            else m_cnt = m_cnt - 1;
          end
        endcase
      end
      m_gh = (m_st == 1);
      m_gl = (m_st == 2);
    end
  endtask

  task automatic chk(input string tag, input logic eh, input logic el);
    checks++;
    if (gate_hi !== eh || gate_lo !== el) begin
      errors++;
      $display("FAIL %s: gate_hi,gate_lo got %b%b expected %b%b at %0t", tag, gate_hi, gate_lo, eh, el, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive at falling edge, update model at rising edge, compare at next falling edge
  task automatic cyc(input logic hn, input logic lo, input logic [1:0] md,
                     input logic [DT_W-1:0] dt, input logic sd);
    string tag;
    hi_cmd_n = hn; lo_cmd = lo; mode = md; dt_cycles = dt; shutdown = sd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (sd) tag = "R10 model";
    else if (md[1]) tag = "R9 model";
    else if (md == BYP) tag = "R8 model";
    else tag = "R7 model";
    chk(tag, m_gh, m_gl);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int unused_seed;
    logic hn, lo, sd;
    logic [1:0] md;
    logic [DT_W-1:0] dt;
    unused_seed = $urandom(32'd61453);
    rst = 1'b1; hi_cmd_n = 1'b1; lo_cmd = 1'b0; mode = IL; dt_cycles = 5; shutdown = 1'b0;
    @(negedge clk);
    cyc(1, 0, IL, 5, 0);
    chk("R1 in reset", 1'b0, 1'b0);
    rst = 1'b0;
    cyc(1, 0, IL, 5, 0);
    chk("R1 after reset", 1'b0, 1'b0);

    repeat (3) begin
      cyc(1, 0, IL, 5, 0);
      chk("R2 idle levels", 1'b0, 1'b0);
    end
    cyc(0, 0, IL, 5, 0);
    chk("R2 high request one edge", 1'b1, 1'b0);

    // R3: dead interval of dt+1 cycles
    n = 0;
    cyc(1, 1, IL, 5, 0);
    while (!gate_lo && n < 40) begin
      if (gate_hi) chk("R3 high off", 1'b0, 1'b0);
      n++;
      cyc(1, 1, IL, 5, 0);
    end
    chk_int("R3 dead cycles dt=5", n, 6);

    // R4: dt change mid-interval ignored
    n = 0;
    cyc(0, 0, IL, 5, 0);
    while (!gate_hi && n < 40) begin
      n++;
      cyc(0, 0, IL, 1, 0);
    end
    chk_int("R4 captured dt kept", n, 6);

    // R5: reversal restarts interval
    n = 0;
    cyc(1, 1, IL, 4, 0); n++;
    cyc(1, 1, IL, 4, 0); n++;
    cyc(0, 0, IL, 4, 0);
    while (!gate_hi && n < 40) begin
      if (gate_lo) chk("R5 low stays off", 1'b0, 1'b0);
      n++;
      cyc(0, 0, IL, 4, 0);
    end
    chk_int("R5 restarted interval", n, 7);

    // R6: conflict holds, when on and while dead
    repeat (3) begin
      cyc(0, 1, IL, 4, 0);
      chk("R6 hold high on", 1'b1, 1'b0);
    end
    cyc(1, 0, IL, 2, 0);
    repeat (4) begin
      cyc(0, 1, IL, 2, 0);
      chk("R6 hold in dead", 1'b0, 1'b0);
    end
    repeat (5) cyc(1, 0, IL, 2, 0);

    // R8: bypass
    cyc(0, 1, BYP, 3, 0);
    chk("R8 both on", 1'b1, 1'b1);
    cyc(1, 1, BYP, 3, 0);
    chk("R8 low only", 1'b0, 1'b1);

    // R11: resume interlock after bypass
    n = 0;
    cyc(0, 0, IL, 3, 0);
    while (!gate_hi && n < 40) begin
      if (gate_lo) chk("R11 low off on resume", 1'b0, 1'b0);
      n++;
      cyc(0, 0, IL, 3, 0);
    end
    chk_int("R11 resume interval", n, 4);

    // R9: disabled codes
    cyc(0, 1, 2'b10, 3, 0); chk("R9 code 10", 1'b0, 1'b0);
    cyc(0, 0, 2'b11, 3, 0); chk("R9 code 11", 1'b0, 1'b0);
    cyc(1, 1, 2'b10, 3, 0); chk("R9 code 10 low", 1'b0, 1'b0);

    // R10: shutdown
    cyc(0, 1, BYP, 3, 1); chk("R10 in bypass", 1'b0, 1'b0);
    cyc(0, 0, IL, 3, 1);  chk("R10 in interlock", 1'b0, 1'b0);

    // constrained random
    hn = 1; lo = 0; dt = 3; md = IL; sd = 0;
    for (int i = 0; i < 4000; i++) begin
      int r;
      if ($urandom % 6 == 0) begin hn = 1'($urandom); lo = 1'($urandom); end
      if ($urandom % 50 == 0) begin
        r = int'($urandom % 16);
        md = (r < 10) ? IL : (r < 13) ? BYP : {1'b1, 1'(r)};
      end
      if ($urandom % 20 == 0) dt = DT_W'($urandom % 7);
      sd = ($urandom % 60 == 0);
      cyc(hn, lo, md, dt, sd);
      if (md == IL && !sd && gate_hi && gate_lo) chk("R7 both on", 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule